// File: doc/BRIEF.md
# Host-Resident Interrupt Vector Fetch Engine

This engine raises a message-signalled interrupt for a device whose vector table sits in host memory rather than in local flops. An interrupt request names a vector index. The engine first reads the 64-bit message address of that entry from host memory with a non-posted read, then reads the 32-bit message data word with a second, separate non-posted read. It then emits a posted write that carries the data word to the fetched address.

Host vector entries change very rarely, so a small fully associative cache of recently fetched entries sits in front of the fetch path. A hit skips both reads and starts the posted write at once. An invalidate input removes one entry by index, or every entry, so that software can force a refetch after it rewrites a vector. Only one interrupt is in flight at a time. A read completion that carries an error drops the interrupt and sets a sticky error flag.

Top module: `msix_fetch_engine`

## Requirements
- R1: `irq_ready` is high only while no interrupt is in flight. A request is taken on a cycle with `irq_valid` and `irq_ready` both high. `irq_ready` stays low from the cycle after that until the cycle after the posted write is accepted (`wr_valid` and `wr_ready`) or the sequence aborts.
- R2: On a cache miss, the first read asks for the message address at `tbl_base + index*16` with `rd_req_dwords` = 2. Valid, address, tag and length hold steady until the cycle `rd_req_grant` is high.
- R3: The second read asks for the message data at `tbl_base + index*16 + 8` with `rd_req_dwords` = 1. It is issued only after the address completion arrives, and never while a read is outstanding.
- R4: The posted write carries the 64-bit `cpl_data` of the address completion as `wr_addr` and bits 31:0 of the data completion's `cpl_data` as `wr_data`. Both stay stable until `wr_ready`.
- R5: On a cache hit, no read is issued and `wr_valid` is high in the cycle right after the request is taken.
- R6: The cache holds 4 entries tagged by vector index. A successful fetch always writes the slot under a round-robin pointer. The pointer starts at slot 0 after reset and advances by one per fill, whether or not a free slot exists. Hits do not move it.
- R7: `inv_valid` with `inv_all` = 1 clears every entry, and with `inv_all` = 0 it clears only the entry tagged `inv_index`. An invalidate of the requested index in the same cycle as the request forces a miss. An invalidate of the index being fetched, seen during the fetch, keeps the fetched entry out of the cache.
- R8: A completion whose `cpl_tag` differs from the outstanding request's tag is ignored: its data and error flag have no effect.
- R9: A matching completion with `cpl_err` high aborts the sequence. No further read and no write is issued, `irq_ready` returns high the next cycle, `err_sticky` sets and stays set until reset, and the cache is left unchanged.
- R10: After reset, `irq_ready` = 1, `rd_req_valid` = 0, `wr_valid` = 0, `err_sticky` = 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 64 | Host address of vector entry 0 |
| irq_valid | input | 1 | Interrupt request |
| irq_index | input | IDX_W | Vector index of the request |
| irq_ready | output | 1 | Engine idle, request can be taken |
| inv_valid | input | 1 | Invalidate strobe |
| inv_all | input | 1 | Invalidate every cached entry |
| inv_index | input | IDX_W | Index to invalidate |
| rd_req_valid | output | 1 | Non-posted read request |
| rd_req_grant | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Read address |
| rd_req_dwords | output | 2 | Read length in 32-bit words |
| rd_req_tag | output | TAG_W | Read request tag |
| cpl_valid | input | 1 | Completion strobe |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_err | input | 1 | Completion reports an error |
| cpl_data | input | 64 | Completion payload |
| wr_valid | output | 1 | Posted write request |
| wr_ready | input | 1 | Posted write accepted |
| wr_addr | output | 64 | Message address |
| wr_data | output | 32 | Message data |
| err_sticky | output | 1 | A fetch has failed since reset |

## Verification
A hit shows `wr_valid` one cycle after the request is taken. A miss shows the first read request one cycle after it is taken. The second read shows one cycle after the edge that accepts the address completion, and `wr_valid` one cycle after the data completion. `irq_ready` returns one cycle after the write handshake or the failing completion. The bench drives and samples on the falling edge and counts whole cycles from the taking edge, so every check reads a value that has settled after the register that produces it. The number of reads seen per interrupt (0, 1 or 2) is compared with a bench model of the round-robin cache to confirm hits, evictions and invalidations.

// File: rtl/msixf_pkg.sv
package msixf_pkg;

   localparam int MSG_ADDR_W = 64;
   localparam int MSG_DATA_W = 32;

   typedef struct packed {
      logic [MSG_ADDR_W-1:0] addr;
      logic [MSG_DATA_W-1:0] data;
   } msix_vec_t;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_ADDR_REQ  = 3'd1,
      ST_ADDR_WAIT = 3'd2,
      ST_DATA_REQ  = 3'd3,
      ST_DATA_WAIT = 3'd4,
      ST_SEND      = 3'd5
   } msixf_state_e;

endpackage

// File: rtl/msixf_addr_gen.sv
module msixf_addr_gen #(
   parameter int IDX_W      = 11,
   parameter int STRIDE_LG2 = 4
) (
   input  logic [63:0]      base,
   input  logic [IDX_W-1:0] index,
   input  logic             second,
   output logic [63:0]      addr
);
   localparam int PAD_W = 64 - IDX_W;

   logic [63:0] offs;

   always_comb begin
      offs = {{PAD_W{1'b0}}, index} << STRIDE_LG2;
      addr = base + offs + (second ? 64'd8 : 64'd0);
   end
endmodule

// File: rtl/msixf_vec_cache.sv
module msixf_vec_cache
   import msixf_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_index,
   output logic             lk_hit,
   output msix_vec_t        lk_entry,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_index,
   input  msix_vec_t        fill_entry,
   input  logic             inv_en,
   input  logic             inv_all,
   input  logic [IDX_W-1:0] inv_index
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DEPTH-1:0]       slot_v;
   logic [IDX_W-1:0]       slot_tag [DEPTH];
   msix_vec_t              slot_ent [DEPTH];
   logic [DEPTH-1:0]       slot_match;
   logic [PTR_W-1:0]       rr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rr_q <= '0;
      else if (fill_en)
         rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_v[s]   <= 1'b0;
            slot_tag[s] <= '0;
            slot_ent[s] <= '0;
         end else begin
            if (inv_en && (inv_all || slot_tag[s] == inv_index))
               slot_v[s] <= 1'b0;
            if (fill_en && rr_q == PTR_W'(s)) begin
               slot_v[s]   <= 1'b1;
               slot_tag[s] <= fill_index;
               slot_ent[s] <= fill_entry;
            end
         end
      end
      assign slot_match[s] = slot_v[s] && (slot_tag[s] == lk_index);
   end

   always_comb begin
      lk_hit   = 1'b0;
      lk_entry = '0;
      for (int s = 0; s < DEPTH; s++) begin
         if (slot_match[s] && !lk_hit) begin
            lk_hit   = 1'b1;
            lk_entry = slot_ent[s];
         end
      end
   end
endmodule

// File: rtl/msixf_seq.sv
module msixf_seq
   import msixf_pkg::*;
#(
   parameter int IDX_W = 11,
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_valid,
   input  logic [IDX_W-1:0] irq_index,
   output logic             irq_ready,
   input  logic             lk_hit,
   input  msix_vec_t        lk_entry,
   input  logic             inv_valid,
   input  logic             inv_all,
   input  logic [IDX_W-1:0] inv_index,
   output logic             rd_req_valid,
   input  logic             rd_req_grant,
   output logic             rd_is_data,
   output logic [1:0]       rd_req_dwords,
   output logic [TAG_W-1:0] rd_req_tag,
   input  logic             cpl_valid,
   input  logic [TAG_W-1:0] cpl_tag,
   input  logic             cpl_err,
   input  logic [63:0]      cpl_data,
   output logic             wr_valid,
   input  logic             wr_ready,
   output logic [63:0]      wr_addr,
   output logic [31:0]      wr_data,
   output logic             fill_en,
   output logic [IDX_W-1:0] fill_index,
   output msix_vec_t        fill_entry,
   output logic [IDX_W-1:0] cur_index,
   output logic             err_sticky
);
   msixf_state_e     st_q, st_d;
   logic [IDX_W-1:0] idx_q;
   logic [63:0]      addr_q;
   logic [31:0]      data_q;
   logic [TAG_W-1:0] tag_q;
   logic             stale_q;
   logic             err_q;

   logic inv_cur, inv_new, accept, use_hit, waiting, cpl_ok;

   always_comb begin
      inv_cur = inv_valid && (inv_all || inv_index == idx_q);
      inv_new = inv_valid && (inv_all || inv_index == irq_index);
      accept  = irq_valid && (st_q == ST_IDLE);
      use_hit = lk_hit && !inv_new;
      waiting = (st_q == ST_ADDR_WAIT) || (st_q == ST_DATA_WAIT);
      cpl_ok  = waiting && cpl_valid && (cpl_tag == tag_q);
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:      if (accept) st_d = use_hit ? ST_SEND : ST_ADDR_REQ;
         ST_ADDR_REQ:  if (rd_req_grant) st_d = ST_ADDR_WAIT;
         ST_ADDR_WAIT: if (cpl_ok) st_d = cpl_err ? ST_IDLE : ST_DATA_REQ;
         ST_DATA_REQ:  if (rd_req_grant) st_d = ST_DATA_WAIT;
         ST_DATA_WAIT: if (cpl_ok) st_d = cpl_err ? ST_IDLE : ST_SEND;
         ST_SEND:      if (wr_ready) st_d = ST_IDLE;
         default:      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         idx_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         tag_q   <= '0;
         stale_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            idx_q   <= irq_index;
            stale_q <= 1'b0;
            if (use_hit) begin
               addr_q <= lk_entry.addr;
               data_q <= lk_entry.data;
            end
         end else if (st_q != ST_IDLE && inv_cur) begin
            stale_q <= 1'b1;
         end
         if (cpl_ok) begin
            tag_q <= tag_q + 1'b1;
            if (cpl_err)
               err_q <= 1'b1;
            else if (st_q == ST_ADDR_WAIT)
               addr_q <= cpl_data;
            else
               data_q <= cpl_data[31:0];
         end
      end
   end

   always_comb begin
      irq_ready     = (st_q == ST_IDLE);
      rd_req_valid  = (st_q == ST_ADDR_REQ) || (st_q == ST_DATA_REQ);
      rd_is_data    = (st_q == ST_DATA_REQ);
      rd_req_dwords = rd_is_data ? 2'd1 : 2'd2;
      rd_req_tag    = tag_q;
      wr_valid      = (st_q == ST_SEND);
      wr_addr       = addr_q;
      wr_data       = data_q;
      fill_en       = cpl_ok && !cpl_err && (st_q == ST_DATA_WAIT)
                      && !stale_q && !inv_cur;
      fill_index    = idx_q;
      fill_entry    = '{addr: addr_q, data: cpl_data[31:0]};
      cur_index     = idx_q;
      err_sticky    = err_q;
   end
endmodule

// File: rtl/msix_fetch_engine.sv
module msix_fetch_engine
   import msixf_pkg::*;
#(
   parameter int IDX_W       = 11,
   parameter int CACHE_DEPTH = 4,
   parameter bit USE_CACHE   = 1'b1,
   parameter int TAG_W       = 4,
   parameter int STRIDE_LG2  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [63:0]      tbl_base,
   input  logic             irq_valid,
   input  logic [IDX_W-1:0] irq_index,
   output logic             irq_ready,
   input  logic             inv_valid,
   input  logic             inv_all,
   input  logic [IDX_W-1:0] inv_index,
   output logic             rd_req_valid,
   input  logic             rd_req_grant,
   output logic [63:0]      rd_req_addr,
   output logic [1:0]       rd_req_dwords,
   output logic [TAG_W-1:0] rd_req_tag,
   input  logic             cpl_valid,
   input  logic [TAG_W-1:0] cpl_tag,
   input  logic             cpl_err,
   input  logic [63:0]      cpl_data,
   output logic             wr_valid,
   input  logic             wr_ready,
   output logic [63:0]      wr_addr,
   output logic [31:0]      wr_data,
   output logic             err_sticky
);
   if (IDX_W < 1 || IDX_W > 32) begin : g_bad_idx
      $error("IDX_W must lie in 1..32");
   end
   if (STRIDE_LG2 < 4 || STRIDE_LG2 + IDX_W > 63) begin : g_bad_stride
      $error("STRIDE_LG2 must be at least 4 and fit the address");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be at least 1");
   end
   if (USE_CACHE && CACHE_DEPTH < 1) begin : g_bad_depth
      $error("CACHE_DEPTH must be at least 1 when the cache is used");
   end

   logic             lk_hit;
   msix_vec_t        lk_entry;
   logic             fill_en;
   logic [IDX_W-1:0] fill_index;
   msix_vec_t        fill_entry;
   logic [IDX_W-1:0] cur_index;
   logic             rd_is_data;

   msixf_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_valid     (irq_valid),
      .irq_index     (irq_index),
      .irq_ready     (irq_ready),
      .lk_hit        (lk_hit),
      .lk_entry      (lk_entry),
      .inv_valid     (inv_valid),
      .inv_all       (inv_all),
      .inv_index     (inv_index),
      .rd_req_valid  (rd_req_valid),
      .rd_req_grant  (rd_req_grant),
      .rd_is_data    (rd_is_data),
      .rd_req_dwords (rd_req_dwords),
      .rd_req_tag    (rd_req_tag),
      .cpl_valid     (cpl_valid),
      .cpl_tag       (cpl_tag),
      .cpl_err       (cpl_err),
      .cpl_data      (cpl_data),
      .wr_valid      (wr_valid),
      .wr_ready      (wr_ready),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .fill_en       (fill_en),
      .fill_index    (fill_index),
      .fill_entry    (fill_entry),
      .cur_index     (cur_index),
      .err_sticky    (err_sticky)
   );

   msixf_addr_gen #(.IDX_W(IDX_W), .STRIDE_LG2(STRIDE_LG2)) u_addr (
      .base   (tbl_base),
      .index  (cur_index),
      .second (rd_is_data),
      .addr   (rd_req_addr)
   );

   if (USE_CACHE) begin : g_cache
      msixf_vec_cache #(.DEPTH(CACHE_DEPTH), .IDX_W(IDX_W)) u_cache (
         .clk        (clk),
         .rst_n      (rst_n),
         .lk_index   (irq_index),
         .lk_hit     (lk_hit),
         .lk_entry   (lk_entry),
         .fill_en    (fill_en),
         .fill_index (fill_index),
         .fill_entry (fill_entry),
         .inv_en     (inv_valid),
         .inv_all    (inv_all),
         .inv_index  (inv_index)
      );
   end else begin : g_nocache
      assign lk_hit   = 1'b0;
      assign lk_entry = '0;
   end
endmodule

// File: rtl/msixf_checker.sv
module msixf_checker #(
   parameter int TAG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_ready,
   input logic             rd_req_valid,
   input logic             rd_req_grant,
   input logic [63:0]      rd_req_addr,
   input logic [1:0]       rd_req_dwords,
   input logic [TAG_W-1:0] rd_req_tag,
   input logic             wr_valid,
   input logic             wr_ready,
   input logic [63:0]      wr_addr,
   input logic [31:0]      wr_data,
   input logic             err_sticky
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ready |-> (!rd_req_valid && !wr_valid));

   assert_ready_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> irq_ready);

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_grant) |=> (rd_req_valid && $stable(rd_req_addr)
         && $stable(rd_req_tag) && $stable(rd_req_dwords)));

   assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && rd_req_grant) |=> !rd_req_valid);

   assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_valid && wr_valid));

   assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   assert_err_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);
endmodule

bind msix_fetch_engine msixf_checker #(.TAG_W(TAG_W)) u_msixf_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .irq_ready     (irq_ready),
   .rd_req_valid  (rd_req_valid),
   .rd_req_grant  (rd_req_grant),
   .rd_req_addr   (rd_req_addr),
   .rd_req_dwords (rd_req_dwords),
   .rd_req_tag    (rd_req_tag),
   .wr_valid      (wr_valid),
   .wr_ready      (wr_ready),
   .wr_addr       (wr_addr),
   .wr_data       (wr_data),
   .err_sticky    (err_sticky)
);

// File: tb/msix_fetch_engine_test.sv
`timescale 1ns/1ps
module msix_fetch_engine_test;
   localparam int IDX_W = 11;
   localparam int TAG_W = 4;
   localparam int NVEC  = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [63:0]      tbl_base = 64'h0000_0040_1234_0000;
   logic             irq_valid = 1'b0;
   logic [IDX_W-1:0] irq_index = '0;
   logic             irq_ready;
   logic             inv_valid = 1'b0;
   logic             inv_all = 1'b0;
   logic [IDX_W-1:0] inv_index = '0;
   logic             rd_req_valid;
   logic             rd_req_grant = 1'b0;
   logic [63:0]      rd_req_addr;
   logic [1:0]       rd_req_dwords;
   logic [TAG_W-1:0] rd_req_tag;
   logic             cpl_valid = 1'b0;
   logic [TAG_W-1:0] cpl_tag = '0;
   logic             cpl_err = 1'b0;
   logic [63:0]      cpl_data = '0;
   logic             wr_valid;
   logic             wr_ready = 1'b0;
   logic [63:0]      wr_addr;
   logic [31:0]      wr_data;
   logic             err_sticky;

   always #2 clk = ~clk;

   msix_fetch_engine #(.IDX_W(IDX_W), .TAG_W(TAG_W)) uut (
      .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
      .irq_valid(irq_valid), .irq_index(irq_index), .irq_ready(irq_ready),
      .inv_valid(inv_valid), .inv_all(inv_all), .inv_index(inv_index),
      .rd_req_valid(rd_req_valid), .rd_req_grant(rd_req_grant),
      .rd_req_addr(rd_req_addr), .rd_req_dwords(rd_req_dwords),
      .rd_req_tag(rd_req_tag), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
      .cpl_err(cpl_err), .cpl_data(cpl_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .err_sticky(err_sticky)
   );

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit finished = 1'b0;

   logic [63:0] addr_tab [NVEC];
   logic [31:0] data_tab [NVEC];
   bit          exp_err = 1'b0;

   // bench model of the 4-slot round-robin cache (R6, R7)
   bit       m_v   [4];
   int       m_idx [4];
   int       m_rr = 0;

   function automatic bit model_hit(input int idx);
      for (int s = 0; s < 4; s++)
         if (m_v[s] && m_idx[s] == idx) return 1'b1;
      return 1'b0;
   endfunction

   function automatic void model_inv(input int idx, input bit all);
      for (int s = 0; s < 4; s++)
         if (all || m_idx[s] == idx) m_v[s] = 1'b0;
   endfunction

   function automatic void model_fill(input int idx);
      m_v[m_rr]   = 1'b1;
      m_idx[m_rr] = idx;
      m_rr = (m_rr + 1) % 4;
   endfunction

   function automatic logic [63:0] exp_rd_addr(input int idx, input bit second);
      return tbl_base + (64'(idx) << 4) + (second ? 64'd8 : 64'd0);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_inv(input int idx, input bit all);
      @(negedge clk);
      inv_valid = 1'b1; inv_all = all; inv_index = IDX_W'(idx);
      @(negedge clk);
      inv_valid = 1'b0; inv_all = 1'b0;
      model_inv(idx, all);
   endtask

   // err_mode: 0 none, 1 error on address completion, 2 on data completion
   task automatic do_irq(input int idx, input int err_mode, input bit bad_tag,
                         input bit mid_inv, input bit acc_inv);
      bit exp_hit, pending, bad_pend, errored, fin_wr, fin_err, done, seen_wr, inv_mid_done;
      int nreads, cdelay, cyc, exp_reads;
      logic [TAG_W-1:0] tag_cap;
      if (acc_inv) model_inv(idx, 1'b0);
      exp_hit = model_hit(idx);
      pending = 0; bad_pend = 0; errored = 0; fin_wr = 0; fin_err = 0;
      done = 0; seen_wr = 0; inv_mid_done = 0; nreads = 0; cdelay = 0; tag_cap = '0;
      @(negedge clk);
      chk(irq_ready == 1'b1, "R1", "ready before request", 64'(irq_ready), 64'd1);
      irq_valid = 1'b1; irq_index = IDX_W'(idx);
      if (acc_inv) begin
         inv_valid = 1'b1; inv_all = 1'b0; inv_index = IDX_W'(idx);
      end
      @(negedge clk);
      irq_valid = 1'b0; inv_valid = 1'b0;
      cyc = 1;
      chk(irq_ready == 1'b0, "R1", "ready low while busy", 64'(irq_ready), 64'd0);
      if (exp_hit)
         chk(wr_valid && !rd_req_valid, "R5", "hit writes next cycle",
             {62'd0, wr_valid, rd_req_valid}, 64'd2);
      else
         chk(rd_req_valid && !wr_valid, "R2", "miss reads next cycle",
             {62'd0, wr_valid, rd_req_valid}, 64'd1);
      while (!done) begin
         rd_req_grant = 1'b0; cpl_valid = 1'b0; cpl_err = 1'b0; wr_ready = 1'b0;
         if (inv_valid) begin inv_valid = 1'b0; end
         if (cyc > 400) begin
            chk(1'b0, "R1", "interrupt never finished", 64'(cyc), 64'd400);
            done = 1;
         end else if (fin_wr) begin
            chk(irq_ready && !wr_valid, "R1", "ready after write accepted",
                {62'd0, irq_ready, wr_valid}, 64'd2);
            done = 1;
         end else if (fin_err) begin
            chk(irq_ready && !wr_valid && !rd_req_valid, "R9", "abort returns idle",
                {61'd0, irq_ready, wr_valid, rd_req_valid}, 64'd4);
            chk(err_sticky == 1'b1, "R9", "error flag set", 64'(err_sticky), 64'd1);
            done = 1;
         end else begin
            if (rd_req_valid) begin
               if (pending) begin
                  chk(1'b0, "R3", "read issued while one outstanding", 64'(nreads), 64'd0);
                  done = 1;
               end else if ($urandom_range(2) != 0) begin
                  chk(rd_req_addr == exp_rd_addr(idx, nreads == 1),
                      nreads == 1 ? "R3" : "R2", "read address",
                      rd_req_addr, exp_rd_addr(idx, nreads == 1));
                  chk(rd_req_dwords == (nreads == 1 ? 2'd1 : 2'd2),
                      nreads == 1 ? "R3" : "R2", "read length",
                      64'(rd_req_dwords), nreads == 1 ? 64'd1 : 64'd2);
                  tag_cap = rd_req_tag;
                  rd_req_grant = 1'b1;
                  nreads++;
                  pending = 1;
                  bad_pend = bad_tag;
                  cdelay = $urandom_range(3);
                  if (mid_inv && !inv_mid_done) begin
                     inv_valid = 1'b1; inv_all = 1'b0; inv_index = IDX_W'(idx);
                     inv_mid_done = 1;
                  end
               end
            end else if (pending) begin
               if (cdelay > 0) cdelay--;
               else if (bad_pend) begin
                  // R8: wrong tag, garbage payload and error flag, must be ignored
                  cpl_valid = 1'b1; cpl_tag = tag_cap + 1'b1; cpl_err = 1'b1;
                  cpl_data = {$urandom, $urandom};
                  bad_pend = 0;
               end else begin
                  cpl_valid = 1'b1; cpl_tag = tag_cap;
                  cpl_err = (err_mode == nreads);
                  cpl_data = (nreads == 1) ? addr_tab[idx] : {$urandom, data_tab[idx]};
                  pending = 0;
                  if (cpl_err) begin errored = 1; fin_err = 1; exp_err = 1; end
               end
            end
            if (wr_valid) begin
               if (!seen_wr) begin
                  chk(wr_addr == addr_tab[idx], "R4", "message address", wr_addr, addr_tab[idx]);
                  chk(wr_data == data_tab[idx], "R4", "message data",
                      64'(wr_data), 64'(data_tab[idx]));
                  seen_wr = 1;
               end
               if ($urandom_range(1) != 0) begin
                  wr_ready = 1'b1; fin_wr = 1;
               end
            end
         end
         @(negedge clk);
         cyc++;
      end
      rd_req_grant = 1'b0; cpl_valid = 1'b0; cpl_err = 1'b0; wr_ready = 1'b0; inv_valid = 1'b0;
      exp_reads = exp_hit ? 0 : (err_mode == 1 ? 1 : 2);
      chk(nreads == exp_reads, exp_hit ? "R6" : "R6", "reads per interrupt",
          64'(nreads), 64'(exp_reads));
      if (errored)
         chk(seen_wr == 1'b0, "R9", "no write after error", 64'(seen_wr), 64'd0);
      chk(err_sticky == exp_err, "R9", "sticky error", 64'(err_sticky), 64'(exp_err));
      if (!exp_hit && !errored && !mid_inv) model_fill(idx);
   endtask

   task automatic rewrite_vec(input int idx);
      addr_tab[idx] = {32'hFEE0_0000 | 32'($urandom_range(255)), $urandom};
      data_tab[idx] = $urandom;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0A17);
      for (int i = 0; i < NVEC; i++) rewrite_vec(i);
      for (int s = 0; s < 4; s++) begin m_v[s] = 0; m_idx[s] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_ready == 1'b1, "R10", "reset ready", 64'(irq_ready), 64'd1);
      chk(rd_req_valid == 1'b0, "R10", "reset read idle", 64'(rd_req_valid), 64'd0);
      chk(wr_valid == 1'b0, "R10", "reset write idle", 64'(wr_valid), 64'd0);
      chk(err_sticky == 1'b0, "R10", "reset error clear", 64'(err_sticky), 64'd0);

      // directed: miss, hit, rewrite plus single invalidate (R5, R6, R7)
      do_irq(3, 0, 0, 0, 0);
      do_irq(3, 0, 0, 0, 0);
      rewrite_vec(3);
      do_inv(3, 0);
      do_irq(3, 0, 0, 0, 0);
      // fill and evict by round robin (R6)
      do_irq(0, 0, 0, 0, 0);
      do_irq(1, 0, 0, 0, 0);
      do_irq(2, 0, 0, 0, 0);
      do_irq(4, 0, 0, 0, 0);
      do_irq(3, 0, 0, 0, 0);
      do_irq(2, 0, 0, 0, 0);
      // wrong-tag completions ignored (R8)
      do_irq(6, 0, 1, 0, 0);
      // invalidate on the request cycle forces a miss (R7)
      do_irq(6, 0, 0, 0, 1);
      // invalidate during fetch keeps entry out (R7)
      do_irq(7, 0, 0, 1, 0);
      do_irq(7, 0, 0, 0, 0);
      // errors on each completion, cache unchanged (R9)
      do_irq(9, 1, 0, 0, 0);
      do_irq(10, 2, 0, 0, 0);
      do_irq(9, 0, 0, 0, 0);
      // invalidate all (R7)
      do_inv(0, 1);
      do_irq(9, 0, 0, 0, 0);

      for (int n = 0; n < 120; n++) begin
         int idx, r;
         idx = $urandom_range(7);
         r = $urandom_range(19);
         if (r == 0) begin
            rewrite_vec(idx);
            do_inv(idx, 0);
         end else if (r == 1) begin
            rewrite_vec(idx);
            do_inv(0, 1);
         end
         if (model_hit(idx))
            do_irq(idx, 0, 0, 0, r == 2);
         else
            do_irq(idx, r == 3 ? 1 : (r == 4 ? 2 : 0), r == 5, r == 6, r == 7);
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end
endmodule